// File: doc/BRIEF.md
# Peripheral Reset Control Bank

This block holds the reset lines of a chip's peripherals in two 32-bit control words that sit on a simple register bus. Each bit of a word drives one peripheral's reset: a 1 holds that peripheral in reset and a 0 lets it run. Software can write a control word whole. It can also change single resets with no read-modify-write, through two write-only alias addresses per word. One alias sets the bits written as 1 and the other clears them.

Only the bit positions that carry a reset function can change; every other position stays 0. The bus is a single-cycle strobe. A write lands in the control word at the next rising clock edge, and read data is returned combinationally in the same cycle as the read strobe. The reset outputs come straight from the stored bits, registered and active high.

Top module: `rst_ctrl_bank`

## Requirements
- R1: After reset every reset output is 0, and reading either control word returns 0.
- R2: A write to offset 0x44 (word 0) or 0x48 (word 1) loads that word's implemented bits from the write data. A read at the same offset returns the stored word.
- R3: A write to the set alias (0x4C for word 0, 0x50 for word 1) sets every implemented bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to the clear alias (0x54 for word 0, 0x58 for word 1) clears every implemented bit written as 1 and leaves bits written as 0 unchanged.
- R5: Only implemented bits can ever be 1. These are mask 0x003FFEFF for word 0 (bits 0-7 and 9-21) and mask 0x0C400000 for word 1 (bits 22, 26 and 27). Writes of 1 to any other position have no effect.
- R6: Reads of the four alias offsets and of any unmapped offset return 0.
- R7: A write to one word, direct or through an alias, leaves the other word unchanged.
- R8: Each reset output equals its stored bit, active high. It changes at the first rising edge that samples the write strobe and not before.
- R9: With the write strobe low, nothing changes, whatever the address, write data or read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Single-cycle write strobe |
| busRead | input | 1 | Read strobe |
| busAddr | input | ADDR_W (8) | Byte offset of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, valid in the cycle of busRead |
| periphRst0 | output | DATA_W (32) | Reset lines from control word 0 |
| periphRst1 | output | DATA_W (32) | Reset lines from control word 1 |

## Verification
The hardest case to reach from the ports is proving that an alias write touches only the bits written as 1. This must hold while neighbouring bits already hold a mix of set and cleared values, and while the other word holds a pattern of its own. The stimulus first loads both words with distinct patterns through direct writes. It then issues sparse set and clear writes whose ones cover set, cleared and reserved positions together, and compares both words against a bench model after each write. Separate writes to reserved positions and reads of the write-only offsets show that these leave no trace at the ports.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int WORDS       = 2;
  localparam int CTRL_BASE   = 'h44;
  localparam int SET_BASE    = 'h4C;
  localparam int CLR_BASE    = 'h54;
  localparam int WORD_STRIDE = 4;

  typedef struct packed {
    logic [WORDS-1:0] wrDirect;
    logic [WORDS-1:0] wrSet;
    logic [WORDS-1:0] wrClr;
    logic [WORDS-1:0] rdCtrl;
  } bankStrobes_t;
endpackage

// File: rtl/rst_ctrl_decode.sv
module rst_ctrl_decode
  import rst_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output bankStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    for (int w = 0; w < WORDS; w++) begin
      strobes.wrDirect[w] = busWrite && (int'(busAddr) == CTRL_BASE + WORD_STRIDE * w);
      strobes.wrSet[w]    = busWrite && (int'(busAddr) == SET_BASE + WORD_STRIDE * w);
      strobes.wrClr[w]    = busWrite && (int'(busAddr) == CLR_BASE + WORD_STRIDE * w);
      strobes.rdCtrl[w]   = busRead && (int'(busAddr) == CTRL_BASE + WORD_STRIDE * w);
    end
  end
endmodule

// File: rtl/rst_ctrl_datapath.sv
module rst_ctrl_datapath
  import rst_ctrl_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK0 = 32'h003F_FEFF,
  parameter logic [DATA_W-1:0] IMPL_MASK1 = 32'h0C40_0000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStrobes_t                  strobes,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [WORDS-1:0][DATA_W-1:0]  ctrlQ
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] WordMask = (w == 0) ? IMPL_MASK0 : IMPL_MASK1;
    logic [DATA_W-1:0] wordQ;
    logic [DATA_W-1:0] wordNext;

    // Set is applied before clear, so clear wins if both ever arrive together.
    always_comb begin
      wordNext = wordQ;
      if (strobes.wrDirect[w]) wordNext = wrData;
      if (strobes.wrSet[w])    wordNext = wordNext | wrData;
      if (strobes.wrClr[w])    wordNext = wordNext & ~wrData;
      wordNext = wordNext & WordMask;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else       wordQ <= wordNext;
    end

    assign ctrlQ[w] = wordQ;
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (strobes.rdCtrl[w]) rdData = rdData | ctrlQ[w];
    end
  end
endmodule

// File: rtl/rst_ctrl_bank.sv
module rst_ctrl_bank
  import rst_ctrl_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK0 = 32'h003F_FEFF,
  parameter logic [DATA_W-1:0] IMPL_MASK1 = 32'h0C40_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] periphRst0,
  output logic [DATA_W-1:0] periphRst1
);
  bankStrobes_t                 strobes;
  logic [WORDS-1:0][DATA_W-1:0] ctrlQ;

  rst_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busWrite (busWrite),
    .busRead  (busRead),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  rst_ctrl_datapath #(
    .DATA_W     (DATA_W),
    .IMPL_MASK0 (IMPL_MASK0),
    .IMPL_MASK1 (IMPL_MASK1)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWdata),
    .rdData  (busRdata),
    .ctrlQ   (ctrlQ)
  );

  assign periphRst0 = ctrlQ[0];
  assign periphRst1 = ctrlQ[1];
endmodule

// File: rtl/rst_ctrl_bank_chk.sv
module rst_ctrl_bank_chk #(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK0 = 32'h003F_FEFF,
  parameter logic [DATA_W-1:0] IMPL_MASK1 = 32'h0C40_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic              busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [DATA_W-1:0] periphRst0,
  input logic [DATA_W-1:0] periphRst1
);
  logic hitCtrl0, hitCtrl1, hitSet0, hitClr0, hitAlias;
  assign hitCtrl0 = int'(busAddr) == 'h44;
  assign hitCtrl1 = int'(busAddr) == 'h48;
  assign hitSet0  = int'(busAddr) == 'h4C;
  assign hitClr0  = int'(busAddr) == 'h54;
  assign hitAlias = int'(busAddr) >= 'h4C && int'(busAddr) <= 'h58;

  assert_direct_word1_R2: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && hitCtrl1 |=> periphRst1 == ($past(busWdata) & IMPL_MASK1));

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRead && hitCtrl0 |-> busRdata == periphRst0);

  assert_set_hits_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && hitSet0 |=>
      (periphRst0 & $past(busWdata) & IMPL_MASK0) == ($past(busWdata) & IMPL_MASK0));

  assert_set_spares_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && hitSet0 |=> ((periphRst0 ^ $past(periphRst0)) & ~$past(busWdata)) == '0);

  assert_clear_hits_R4: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && hitClr0 |=> (periphRst0 & $past(busWdata)) == '0);

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((periphRst0 & ~IMPL_MASK0) == '0) && ((periphRst1 & ~IMPL_MASK1) == '0));

  assert_alias_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    busRead && hitAlias |-> busRdata == '0);

  assert_other_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && hitCtrl0 |=> $stable(periphRst1));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(periphRst0) && $stable(periphRst1));
endmodule

bind rst_ctrl_bank rst_ctrl_bank_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .IMPL_MASK0 (IMPL_MASK0),
  .IMPL_MASK1 (IMPL_MASK1)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrite   (busWrite),
  .busRead    (busRead),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .periphRst0 (periphRst0),
  .periphRst1 (periphRst1)
);

// File: tb/rst_ctrl_bank_tb.sv
module rst_ctrl_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [31:0] M0 = 32'h003F_FEFF;
  localparam logic [31:0] M1 = 32'h0C40_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrite = 1'b0;
  logic              busRead = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [DATA_W-1:0] periphRst0;
  logic [DATA_W-1:0] periphRst1;

  logic [31:0] mdl0 = '0;
  logic [31:0] mdl1 = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctrl_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMPL_MASK0(M0), .IMPL_MASK1(M1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periphRst0(periphRst0), .periphRst1(periphRst1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h44: mdl0 = d & M0;
      8'h48: mdl1 = d & M1;
      8'h4C: mdl0 = mdl0 | (d & M0);
      8'h50: mdl1 = mdl1 | (d & M1);
      8'h54: mdl0 = mdl0 & ~d;
      8'h58: mdl1 = mdl1 & ~d;
      default: ;
    endcase
  endtask

  // Strobe for one cycle; on return the edge that took the write has passed.
  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
    modelWrite(a, d);
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRead = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic checkState(input string tag);
    check({tag, " word0"}, periphRst0, mdl0);
    check({tag, " word1"}, periphRst1, mdl1);
  endtask

  task automatic testReset();
    logic [31:0] r;
    check("R1 out0", periphRst0, 32'h0);
    check("R1 out1", periphRst1, 32'h0);
    busRd(8'h44, r); check("R1 read word0", r, 32'h0);
    busRd(8'h48, r); check("R1 read word1", r, 32'h0);
  endtask

  task automatic testDirect();
    logic [31:0] r;
    busWr(8'h44, 32'hFFFF_FFFF);
    checkState("R2 direct all-ones");
    check("R5 word0 mask", periphRst0, M0);
    busRd(8'h44, r); check("R2 readback word0", r, M0);
    busWr(8'h48, 32'hFFFF_FFFF);
    check("R5 word1 mask", periphRst1, M1);
    busWr(8'h48, 32'h0840_0000);
    checkState("R2 direct word1 pattern");
    busRd(8'h48, r); check("R2 readback word1", r, 32'h0840_0000);
    busWr(8'h44, 32'h0012_3456);
    checkState("R2 direct word0 pattern");
  endtask

  task automatic testSet();
    busWr(8'h4C, 32'hF000_0101);   // bit 8 and 28-31 reserved
    checkState("R3 set word0");
    check("R5 set reserved word0", periphRst0 & ~M0, 32'h0);
    busWr(8'h50, 32'h0400_0800);   // bit 26 implemented, bit 11 reserved
    checkState("R3 set word1");
    check("R5 set reserved word1", periphRst1 & 32'h0000_0800, 32'h0);
    busWr(8'h4C, 32'h0);
    checkState("R3 set zero no change");
  endtask

  task automatic testClear();
    busWr(8'h54, 32'h0000_0101);
    checkState("R4 clear word0");
    busWr(8'h58, 32'h0800_0000);
    checkState("R4 clear word1");
    check("R4 bit22 kept", periphRst1 & 32'h0040_0000, 32'h0040_0000);
    busWr(8'h58, 32'h0);
    checkState("R4 clear zero no change");
  endtask

  task automatic testAliasRead();
    logic [31:0] r;
    busRd(8'h4C, r); check("R6 read set0", r, 32'h0);
    busRd(8'h50, r); check("R6 read set1", r, 32'h0);
    busRd(8'h54, r); check("R6 read clr0", r, 32'h0);
    busRd(8'h58, r); check("R6 read clr1", r, 32'h0);
    busRd(8'h40, r); check("R6 read unmapped", r, 32'h0);
  endtask

  task automatic testIsolation();
    logic [31:0] keep1;
    busWr(8'h48, 32'h0C40_0000);
    keep1 = periphRst1;
    busWr(8'h44, 32'hAAAA_AAAA);
    check("R7 word1 after word0 direct", periphRst1, keep1);
    busWr(8'h54, 32'hFFFF_FFFF);
    check("R7 word1 after word0 clear", periphRst1, keep1);
    busWr(8'h4C, 32'h0000_0003);
    busWr(8'h58, 32'h0400_0000);
    check("R7 word0 after word1 clear", periphRst0, 32'h0000_0003);
    checkState("R7 state");
  endtask

  task automatic testTiming();
    @(negedge clk);
    busWrite = 1'b1; busAddr = 8'h4C; busWdata = 32'h0000_0010;
    #1 check("R8 not yet set", periphRst0 & 32'h10, 32'h0);
    @(posedge clk); #1;
    check("R8 set after edge", periphRst0 & 32'h10, 32'h10);
    busWrite = 1'b0; busWdata = '0;
    modelWrite(8'h4C, 32'h0000_0010);
    checkState("R8 state");
  endtask

  task automatic testIdle();
    logic [31:0] r;
    @(negedge clk);
    busAddr = 8'h4C; busWdata = 32'hFFFF_FFFF; busRead = 1'b1;
    @(negedge clk);
    busAddr = 8'h44; busWdata = 32'h0;
    @(negedge clk);
    busRead = 1'b0; busAddr = 8'h58; busWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    busWdata = '0;
    checkState("R9 idle strobes");
    busRd(8'h44, r); check("R9 readback word0", r, mdl0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirect();
    testSet();
    testClear();
    testAliasRead();
    testIsolation();
    testTiming();
    testIdle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule